// File: doc/BRIEF.md
# Latched Channel Select Controller

This block drives the control gates of a bank of analog switches: sixteen single-ended channels, or eight differential pairs with an A switch and a B switch each. A host writes a binary channel number and an enable bit under an active-low write strobe. While the strobe is low the captured values track the inputs. When it goes high they freeze, and the switch vector then ignores the inputs. An active-low reset clears both the captured channel and the captured enable, so every switch is open.

The block runs on a system clock. The strobe, enable and channel inputs pass through a two-stage synchronizer. The capture register is updated on each clock while the synchronized strobe is low. A change from one lit channel to another lit channel passes through a dark gap of `BBM_CYCLES` clocks (at least 1, default 2), with a busy flag high for that gap. Turning a channel on from the all-off state, or turning the lit channel off, takes effect at once. From an input change to the switch outputs there are four clock edges: two synchronizer stages, the capture register and the output register.

Top module: `chsel_top`

## Requirements
- R1: While `wrN` is low, the switch vector follows `chanIn`/`enIn` four clock edges after they change at the ports.
- R2: While `wrN` is high, the switch vector keeps its last value whatever `chanIn` and `enIn` do. The last values seen with `wrN` low are the ones kept.
- R3: A low `rstN` clears all outputs at once, without waiting for a clock edge, and holds them at zero whatever the other inputs do. After release with `wrN` high, the outputs stay zero.
- R4: With the captured enable at 0, every bit of `swDrive` is 0 for any channel value.
- R5: In single-ended mode (`DIFF_MODE`=0, 4-bit `chanIn`), enabled channel value n drives `swDrive[n]` alone.
- R6: In differential mode (`DIFF_MODE`=1, 3-bit `chanIn`), enabled pair value n drives both `swDrive[n]` (A side) and `swDrive[n+8]` (B side), and no other bit.
- R7: A change from one lit channel to a different lit channel holds `swDrive` at zero for exactly `BBM_CYCLES` clocks before the new channel is driven. Off-to-on and on-to-off changes have no gap.
- R8: If the target channel changes again during a gap, the gap restarts at full length and ends on the newest channel. No intermediate channel is ever driven.
- R9: At most one channel (single-ended) or one pair (differential) is driven in any cycle, and a lit output never changes directly into a different lit output.
- R10: `bbmBusy` is high exactly during the dark gap, and a gap starts only from a lit state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset; clears the captured channel and enable |
| chanIn | input | ADDR_W (4 or 3) | Binary channel or pair number |
| enIn | input | 1 | Channel enable |
| wrN | input | 1 | Active-low write strobe; low makes the capture transparent |
| swDrive | output | 16 | Switch gate drive; in differential mode A sides are bits 0-7 and B sides bits 8-15 |
| bbmBusy | output | 1 | High while a break-before-make gap is in progress |

## Verification
A corrupt capture register shows up at `swDrive` four edges after the strobe activity as a wrong channel, or as an output that keeps moving after `wrN` has gone high. A wrong gap counter shows up within `BBM_CYCLES`+1 clocks as a dark interval of the wrong length, a busy flag out of step with the dark outputs, or a direct jump between two lit channels. A stale pending target shows up as an intermediate channel lighting after a restarted gap. The bench samples each of these windows on the exact clock where the change is due.

// File: rtl/chsel_pkg.sv
package chsel_pkg;
  // Strobes from the control to the datapath
  typedef struct packed {
    logic drive;       // light output with current target
    logic blank;       // turn all outputs off
    logic capturePend; // remember target as gap destination
  } chselCtrl_t;

  // Compare flags from the datapath to the control
  typedef struct packed {
    logic tgtOn;
    logic outOn;
    logic tgtNeOut;
    logic tgtNePend;
  } chselStat_t;
endpackage

// File: rtl/chsel_sync.sv
module chsel_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/chsel_datapath.sv
module chsel_datapath
  import chsel_pkg::*;
#(
  parameter bit DIFF_MODE = 1'b0,
  parameter int ADDR_W = 4,
  parameter int NSW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              syncWrN,
  input  logic              syncEn,
  input  logic [ADDR_W-1:0] syncAddr,
  input  chselCtrl_t        ctrl,
  output chselStat_t        stat,
  output logic [NSW-1:0]    swDrive
);
  localparam int NCH = 1 << ADDR_W;

  logic              latchEn;
  logic [ADDR_W-1:0] latchAddr;
  logic [ADDR_W-1:0] pendAddr;
  logic [ADDR_W-1:0] outAddr;
  logic              outOn;

  // Capture register: transparent while the strobe is low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchEn   <= 1'b0;
      latchAddr <= '0;
    end else if (!syncWrN) begin
      latchEn   <= syncEn;
      latchAddr <= syncAddr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendAddr <= '0;
      outAddr  <= '0;
      outOn    <= 1'b0;
    end else begin
      if (ctrl.capturePend) pendAddr <= latchAddr;
      if (ctrl.blank) begin
        outOn <= 1'b0;
      end else if (ctrl.drive) begin
        outOn   <= 1'b1;
        outAddr <= latchAddr;
      end
    end
  end

  always_comb begin
    stat.tgtOn     = latchEn;
    stat.outOn     = outOn;
    stat.tgtNeOut  = (latchAddr != outAddr);
    stat.tgtNePend = (latchAddr != pendAddr);
  end

  generate
    if (DIFF_MODE) begin : g_diff
      for (genvar k = 0; k < NCH; k++) begin : g_pair
        assign swDrive[k]       = outOn && (outAddr == ADDR_W'(k));
        assign swDrive[k + NCH] = outOn && (outAddr == ADDR_W'(k));
      end
    end else begin : g_single
      for (genvar k = 0; k < NCH; k++) begin : g_chan
        assign swDrive[k] = outOn && (outAddr == ADDR_W'(k));
      end
    end
  endgenerate
endmodule

// File: rtl/chsel_ctrl.sv
module chsel_ctrl
  import chsel_pkg::*;
#(
  parameter int BBM_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  chselStat_t stat,
  output chselCtrl_t ctrl,
  output logic       bbmBusy
);
  localparam int CNT_W = $clog2(BBM_CYCLES + 1);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(BBM_CYCLES);

  logic [CNT_W-1:0] gapCnt, nextCnt;

  always_comb begin
    ctrl    = '0;
    nextCnt = gapCnt;
    if (gapCnt == '0) begin
      if (!stat.tgtOn) begin
        ctrl.blank = 1'b1;
      end else if (!stat.outOn) begin
        ctrl.drive = 1'b1;
      end else if (stat.tgtNeOut) begin
        ctrl.blank       = 1'b1;
        ctrl.capturePend = 1'b1;
        nextCnt          = GAP_LOAD;
      end
    end else begin
      if (!stat.tgtOn) begin
        nextCnt = '0;
      end else if (stat.tgtNePend) begin
        ctrl.capturePend = 1'b1;
        nextCnt          = GAP_LOAD;
      end else if (gapCnt == CNT_W'(1)) begin
        ctrl.drive = 1'b1;
        nextCnt    = '0;
      end else begin
        nextCnt = gapCnt - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapCnt <= '0;
    else       gapCnt <= nextCnt;
  end

  assign bbmBusy = (gapCnt != '0);
endmodule

// File: rtl/chsel_top.sv
module chsel_top
  import chsel_pkg::*;
#(
  parameter bit DIFF_MODE = 1'b0,
  parameter int BBM_CYCLES = 2,
  localparam int ADDR_W = DIFF_MODE ? 3 : 4,
  localparam int NSW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] chanIn,
  input  logic              enIn,
  input  logic              wrN,
  output logic [NSW-1:0]    swDrive,
  output logic              bbmBusy
);
  localparam int SW = ADDR_W + 2;

  logic [SW-1:0] syncBus;
  chselCtrl_t    ctrl;
  chselStat_t    stat;

  chsel_sync #(.W(SW), .RST_VAL({1'b1, {(SW-1){1'b0}}})) sync_i (
    .clk  (clk),
    .rstN (rstN),
    .d    ({wrN, enIn, chanIn}),
    .q    (syncBus)
  );

  chsel_datapath #(.DIFF_MODE(DIFF_MODE), .ADDR_W(ADDR_W), .NSW(NSW)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .syncWrN  (syncBus[SW-1]),
    .syncEn   (syncBus[SW-2]),
    .syncAddr (syncBus[ADDR_W-1:0]),
    .ctrl     (ctrl),
    .stat     (stat),
    .swDrive  (swDrive)
  );

  chsel_ctrl #(.BBM_CYCLES(BBM_CYCLES)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .stat    (stat),
    .ctrl    (ctrl),
    .bbmBusy (bbmBusy)
  );
endmodule

// File: rtl/chsel_checker.sv
module chsel_checker #(
  parameter bit DIFF_MODE = 1'b0,
  parameter int NSW = 16
) (
  input logic           clk,
  input logic           rstN,
  input logic [NSW-1:0] swDrive,
  input logic           bbmBusy
);
  localparam int HALF = NSW / 2;

  // R7: the gap is dark
  assert_gap_dark_R7: assert property (@(posedge clk) disable iff (!rstN)
    bbmBusy |-> (swDrive == '0));

  // R9: no direct jump between two lit states
  assert_no_direct_switch_R9: assert property (@(posedge clk) disable iff (!rstN)
    (($past(swDrive) != '0) && (swDrive != '0)) |-> (swDrive == $past(swDrive)));

  // R10: a gap begins only when a channel was lit
  assert_busy_from_lit_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bbmBusy) |-> ($past(swDrive) != '0));

  generate
    if (DIFF_MODE) begin : g_diff
      // R6: A and B sides move together
      assert_pair_match_R6: assert property (@(posedge clk) disable iff (!rstN)
        swDrive[HALF-1:0] == swDrive[NSW-1:HALF]);
      // R9: one pair at most
      assert_one_pair_R9: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(swDrive[HALF-1:0]));
    end else begin : g_single
      // R9: one channel at most
      assert_one_chan_R9: assert property (@(posedge clk) disable iff (!rstN)
        $onehot0(swDrive));
    end
  endgenerate
endmodule

bind chsel_top chsel_checker #(.DIFF_MODE(DIFF_MODE), .NSW(NSW)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .swDrive (swDrive),
  .bbmBusy (bbmBusy)
);

// File: tb/chsel_top_tb_top.sv
module chsel_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  chanIn = '0;
  logic        enIn = 1'b0;
  logic        wrN = 1'b1;
  logic [15:0] swDrive, swDiff;
  logic        bbmBusy, busyDiff;

  int checkCnt = 0;
  int failCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chsel_top #(.DIFF_MODE(1'b0), .BBM_CYCLES(2)) dut_i (
    .clk(clk), .rstN(rstN), .chanIn(chanIn), .enIn(enIn), .wrN(wrN),
    .swDrive(swDrive), .bbmBusy(bbmBusy)
  );

  chsel_top #(.DIFF_MODE(1'b1), .BBM_CYCLES(2)) dutDiff_i (
    .clk(clk), .rstN(rstN), .chanIn(chanIn[2:0]), .enIn(enIn), .wrN(wrN),
    .swDrive(swDiff), .bbmBusy(busyDiff)
  );

  // {chan, en, wrN, expected single-ended swDrive}
  localparam logic [21:0] VEC [NVEC] = '{
    {4'd3,  1'b0, 1'b0, 16'h0000},  // R4
    {4'd3,  1'b1, 1'b0, 16'h0008},  // R1 R5
    {4'd0,  1'b1, 1'b0, 16'h0001},  // R5 first
    {4'd15, 1'b1, 1'b0, 16'h8000},  // R5 last
    {4'd7,  1'b1, 1'b1, 16'h8000},  // R2
    {4'd7,  1'b0, 1'b1, 16'h8000},  // R2
    {4'd7,  1'b0, 1'b0, 16'h0000},  // R4
    {4'd9,  1'b1, 1'b0, 16'h0200},  // R1
    {4'd2,  1'b1, 1'b1, 16'h0200}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
  endtask

  task automatic setIn(input logic [3:0] c, input logic e, input logic w);
    chanIn = c; enIn = e; wrN = w;
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R3 reset sw", {16'h0, swDrive}, 32'h0);
    check("R10 reset busy", {31'h0, bbmBusy}, 32'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      setIn(VEC[i][21:18], VEC[i][17], VEC[i][16]);
      repeat (10) @(negedge clk);
      check($sformatf("R1/R2/R4/R5 vec %0d", i), {16'h0, swDrive}, {16'h0, VEC[i][15:0]});
    end

    // R7 gap length: light 9, then move to 5
    setIn(4'd9, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    setIn(4'd5, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    check("R1 old still lit at edge 3", {16'h0, swDrive}, 32'h0200);
    @(negedge clk);
    check("R7 gap dark 1", {16'h0, swDrive}, 32'h0);
    check("R10 busy 1", {31'h0, bbmBusy}, 32'h1);
    @(negedge clk);
    check("R7 gap dark 2", {16'h0, swDrive}, 32'h0);
    check("R10 busy 2", {31'h0, bbmBusy}, 32'h1);
    @(negedge clk);
    check("R7 new lit", {16'h0, swDrive}, 32'h0020);
    check("R10 busy end", {31'h0, bbmBusy}, 32'h0);

    // R7 on->off and off->on without gap
    setIn(4'd5, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check("R7 off no gap", {15'h0, bbmBusy, swDrive}, 32'h0);
    setIn(4'd6, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    check("R7 on no gap", {15'h0, bbmBusy, swDrive}, 32'h0040);

    // R8 restart: 6 -> 1 -> 12 on consecutive cycles
    setIn(4'd1, 1'b1, 1'b0);
    @(negedge clk);
    setIn(4'd12, 1'b1, 1'b0);
    repeat (3) @(negedge clk);
    for (int j = 0; j < 3; j++) begin
      check("R8 dark during restarted gap", {15'h0, bbmBusy, swDrive}, 32'h10000);
      @(negedge clk);
    end
    check("R8 newest lit", {15'h0, bbmBusy, swDrive}, 32'h1000);

    // R3 async reset with wrN high, then inputs during reset
    setIn(4'd4, 1'b1, 1'b1);
    repeat (5) @(negedge clk);
    #(CLK_PERIOD/4);
    rstN = 1'b0;
    #1;
    check("R3 async clear", {16'h0, swDrive}, 32'h0);
    setIn(4'd4, 1'b1, 1'b0);
    repeat (5) @(negedge clk);
    check("R3 override", {15'h0, bbmBusy, swDrive}, 32'h0);
    setIn(4'd4, 1'b1, 1'b1);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check("R3 cleared stays after release", {16'h0, swDrive}, 32'h0);

    // R6 differential mode
    setIn(4'd2, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    check("R6 pair 2", {16'h0, swDiff}, 32'h0404);
    check("R5 single 2", {16'h0, swDrive}, 32'h0004);
    setIn(4'd7, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    check("R6 pair 7", {16'h0, swDiff}, 32'h8080);
    setIn(4'd7, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    check("R4 R6 pair off", {16'h0, swDiff}, 32'h0);

    summary();
    $finish;
  end
endmodule